// File: doc/BRIEF.md
# HDQ Single-Wire Bus Master

This block is the master end of a single-wire, HDQ-style serial bus. Software reaches it through a small byte-wide register port. It loads a byte to send and then sets a start bit in the control register. The same start bit, combined with a direction bit or a break bit, makes the controller receive one byte from the slave or emit a long bus-reset pulse instead. The wire is open-drain: the block either pulls it low or lets it float high. The slave's activity is read back through a two-stage synchroniser.

Every operation ends by raising one of three completion flags in an interrupt status register. That register clears when it is read. An interrupt output is asserted while any flag is set and interrupts are enabled. With interrupts disabled, reads do not clear the flags and the start and break bits stay set after an operation ends. A soft reset bit returns every register to its default value, and a reset-done bit reports when that reset has finished. A read-only revision byte reports a major and a minor number.

All bus timing is counted in ticks of a prescaler that divides the clock. A normal HDQ exchange is one transmit of a command/address byte followed by either a second transmit or a receive. The receive may be started in the cycle after the transmit completes.

Top module: `hdq_master`

## Requirements
- R1: Register offsets are revision 0x00 (major revision in bits 7:4, minor in bits 3:0), transmit byte 0x04, receive byte 0x08, control 0x0C, interrupt status 0x10, system config 0x14 and system status 0x18. Unmapped offsets read 0. After reset, control, status, transmit, receive and config read 0. The reset-done bit (status bit 0 at 0x18) reads 0 for SRST_CYCLES cycles after reset and then reads 1.
- R2: Control bits are IE=6, CLKEN=5, GO=4, INIT=2, DIR=1 and MODE=0. Writing GO=1 with INIT=0 and DIR=0 sends the transmit byte least significant bit first. Each bit cell is CELL ticks long and starts with a low pulse of ONE_LOW ticks for a 1 or ZERO_LOW ticks for a 0. One tick is TICK_DIV clocks.
- R3: When the eighth bit cell of a transmit ends, TX-done (status bit 2) is set. If IE is 1, GO reads 0 afterwards.
- R4: Writing INIT=1 with GO=1 pulls the line low for BRK_LOW ticks and then releases it for BRK_REC ticks. After that the timeout flag (status bit 0) is set and, with IE=1, INIT and GO read 0.
- R5: Writing GO=1 with DIR=1 receives a byte, least significant bit first. Each bit begins at a slave low edge. The line is sampled RX_SAMPLE ticks later, and high means 1. After eight bits the byte appears at 0x08, RX-done (status bit 1) is set and, with IE=1, GO reads 0.
- R6: In receive, if no slave low edge arrives within RX_WAIT ticks, the timeout flag is set instead of RX-done and GO clears (with IE=1).
- R7: A receive written in the cycle after a transmit completes is accepted. Both TX-done and RX-done then read as set together.
- R8: With IE=1, a read of the status register returns the flags and clears them. The interrupt output equals IE AND (any flag set).
- R9: With IE=0, status reads do not clear the flags, GO stays 1 after an operation ends, and the interrupt output stays 0.
- R10: Writing config bit 1 aborts any operation, releases the line and returns all registers to defaults. Reset-done reads 0 for SRST_CYCLES cycles, and writes in that window are ignored. Config bit 0 (auto-idle) is stored and reads back.
- R11: A write to the control register while an operation runs is ignored.
- R12: The line is pulled low only while GO is set, and never during a receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; a status read clears flags at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when bus_rd is low |
| irq | output | 1 | Interrupt request |
| line_pull_low | output | 1 | Open-drain enable: 1 pulls the wire low |
| line_in | input | 1 | Wire level as seen at the pad |

## Verification
The bench builds the block with a prescaler of 4 clocks per tick. All bit timings are shrunk to a few tens of ticks (1-low 4, 0-low 12, cell 24, break 30+8, receive window 40, sample point 8), and the soft reset lasts 6 cycles. At these values whole byte transfers, breaks and receive timeouts take hundreds of cycles. That makes random bytes in both directions, the back-to-back transmit then receive, the interrupt-disabled behaviour and a soft reset in the middle of a transfer all cheap to reach. The bench models the slave as a second open-drain driver with distinct short and long low pulses. It decodes the master's pulses by width against the midpoint of the two low times.

// File: rtl/hdq_pkg.sv
package hdq_pkg;
    localparam logic [4:0] A_REV  = 5'h00;
    localparam logic [4:0] A_TXD  = 5'h04;
    localparam logic [4:0] A_RXD  = 5'h08;
    localparam logic [4:0] A_CTRL = 5'h0C;
    localparam logic [4:0] A_ISR  = 5'h10;
    localparam logic [4:0] A_SYSC = 5'h14;
    localparam logic [4:0] A_SYSS = 5'h18;

    localparam int C_IE   = 6;
    localparam int C_GO   = 4;
    localparam int C_INIT = 2;
    localparam int C_DIR  = 1;
    localparam logic [7:0] CTRL_MASK = 8'h77;

    localparam int F_TX = 2;
    localparam int F_RX = 1;
    localparam int F_TO = 0;

    typedef enum logic [1:0] {OP_TX, OP_RX, OP_BRK} op_e;

    typedef enum logic [2:0] {
        E_IDLE, E_TX_LOW, E_TX_HIGH, E_BRK_LOW, E_BRK_REC,
        E_RX_WAIT, E_RX_LOW, E_RX_REL
    } eng_st_e;
endpackage

// File: rtl/hdq_sync.sv
module hdq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sr_q;
    logic [STAGES-1:0] sr_d;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                assign sr_d[g] = din;
            end else begin : g_next
                assign sr_d[g] = sr_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '1;
        else        sr_q <= sr_d;
    end

    assign dout = sr_q[STAGES-1];
endmodule

// File: rtl/hdq_prescaler.sv
module hdq_prescaler #(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == W'(DIV - 1));

    always_comb begin
        if (clear || tick) cnt_d = '0;
        else               cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/hdq_line_engine.sv
module hdq_line_engine
    import hdq_pkg::*;
#(
    parameter int ONE_LOW   = 32,
    parameter int ZERO_LOW  = 100,
    parameter int CELL      = 190,
    parameter int BRK_LOW   = 200,
    parameter int BRK_REC   = 50,
    parameter int RX_WAIT   = 400,
    parameter int RX_SAMPLE = 65
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       abort,
    input  logic       tick,
    input  logic       start,
    input  op_e        op,
    input  logic [7:0] tx_byte,
    input  logic       line_s,
    output logic       drive_low,
    output logic       busy,
    output logic [2:0] done_flags,
    output logic [7:0] rx_byte
);
    localparam int M1   = (CELL > BRK_LOW) ? CELL : BRK_LOW;
    localparam int M2   = (RX_WAIT > BRK_REC) ? RX_WAIT : BRK_REC;
    localparam int M3   = (RX_SAMPLE > ZERO_LOW) ? RX_SAMPLE : ZERO_LOW;
    localparam int M12  = (M1 > M2) ? M1 : M2;
    localparam int MAXT = (M12 > M3) ? M12 : M3;
    localparam int TW   = $clog2(MAXT + 1);

    typedef struct packed {
        eng_st_e       st;
        logic [TW-1:0] tcnt;
        logic [2:0]    bidx;
        logic [7:0]    shr;
        logic [7:0]    rxb;
        logic          drv;
        logic [2:0]    done;
    } eng_t;

    eng_t q, d;
    logic [TW-1:0] tn;

    assign tn = q.tcnt + TW'(1);

    always_comb begin
        d      = q;
        d.done = '0;
        case (q.st)
            E_IDLE: begin
                d.drv = 1'b0;
                if (start) begin
                    d.tcnt = '0;
                    d.bidx = '0;
                    case (op)
                        OP_TX: begin
                            d.shr = tx_byte;
                            d.st  = E_TX_LOW;
                            d.drv = 1'b1;
                        end
                        OP_BRK: begin
                            d.st  = E_BRK_LOW;
                            d.drv = 1'b1;
                        end
                        default: d.st = E_RX_WAIT;
                    endcase
                end
            end
            E_TX_LOW: if (tick) begin
                d.tcnt = tn;
                if (tn == (q.shr[0] ? TW'(ONE_LOW) : TW'(ZERO_LOW))) begin
                    d.st  = E_TX_HIGH;
                    d.drv = 1'b0;
                end
            end
            E_TX_HIGH: if (tick) begin
                d.tcnt = tn;
                if (tn == TW'(CELL)) begin
                    if (q.bidx == 3'd7) begin
                        d.st         = E_IDLE;
                        d.done[F_TX] = 1'b1;
                    end else begin
                        d.bidx = q.bidx + 3'd1;
                        d.shr  = {1'b0, q.shr[7:1]};
                        d.tcnt = '0;
                        d.st   = E_TX_LOW;
                        d.drv  = 1'b1;
                    end
                end
            end
            E_BRK_LOW: if (tick) begin
                d.tcnt = tn;
                if (tn == TW'(BRK_LOW)) begin
                    d.st   = E_BRK_REC;
                    d.drv  = 1'b0;
                    d.tcnt = '0;
                end
            end
            E_BRK_REC: if (tick) begin
                d.tcnt = tn;
                if (tn == TW'(BRK_REC)) begin
                    d.st         = E_IDLE;
                    d.done[F_TO] = 1'b1;
                end
            end
            E_RX_WAIT: begin
                if (!line_s) begin
                    d.st   = E_RX_LOW;
                    d.tcnt = '0;
                end else if (tick) begin
                    d.tcnt = tn;
                    if (tn == TW'(RX_WAIT)) begin
                        d.st         = E_IDLE;
                        d.done[F_TO] = 1'b1;
                    end
                end
            end
            E_RX_LOW: if (tick) begin
                d.tcnt = tn;
                if (tn == TW'(RX_SAMPLE)) begin
                    d.shr  = {line_s, q.shr[7:1]};
                    d.st   = E_RX_REL;
                    d.tcnt = '0;
                end
            end
            E_RX_REL: begin
                if (line_s) begin
                    if (q.bidx == 3'd7) begin
                        d.st         = E_IDLE;
                        d.rxb        = q.shr;
                        d.done[F_RX] = 1'b1;
                    end else begin
                        d.bidx = q.bidx + 3'd1;
                        d.tcnt = '0;
                        d.st   = E_RX_WAIT;
                    end
                end else if (tick) begin
                    d.tcnt = tn;
                    if (tn == TW'(RX_WAIT)) begin
                        d.st         = E_IDLE;
                        d.done[F_TO] = 1'b1;
                    end
                end
            end
            default: d.st = E_IDLE;
        endcase
        if (abort) begin
            d.st   = E_IDLE;
            d.drv  = 1'b0;
            d.done = '0;
            d.tcnt = '0;
            d.bidx = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= E_IDLE;
        end else begin
            q <= d;
        end
    end

    assign drive_low  = q.drv;
    assign busy       = (q.st != E_IDLE);
    assign done_flags = q.done;
    assign rx_byte    = q.rxb;
endmodule

// File: rtl/hdq_master.sv
module hdq_master
    import hdq_pkg::*;
#(
    parameter int         TICK_DIV    = 32,
    parameter int         ONE_LOW     = 32,
    parameter int         ZERO_LOW    = 100,
    parameter int         CELL        = 190,
    parameter int         BRK_LOW     = 200,
    parameter int         BRK_REC     = 50,
    parameter int         RX_WAIT     = 400,
    parameter int         RX_SAMPLE   = 65,
    parameter int         SRST_CYCLES = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] REV_MAJOR   = 4'd1,
    parameter logic [3:0] REV_MINOR   = 4'd0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq,
    output logic       line_pull_low,
    input  logic       line_in
);
    localparam int SW = $clog2(SRST_CYCLES + 1);

    typedef struct packed {
        logic [7:0]    ctrl;
        logic [7:0]    txd;
        logic [7:0]    rxd;
        logic [2:0]    flags;
        logic          aidle;
        logic [SW-1:0] srst;
    } regs_t;

    regs_t q, d;

    logic       tick, line_s, eng_busy, eng_start, soft_rst, srst_done;
    logic [2:0] eng_done;
    logic [7:0] eng_rx, rdata;
    op_e        eng_op;
    logic [7:0] chk_ctrl;
    logic [2:0] chk_flags;

    assign srst_done = (q.srst == '0);
    assign soft_rst  = srst_done && bus_wr && (bus_addr == A_SYSC) && bus_wdata[1];
    assign eng_start = srst_done && bus_wr && (bus_addr == A_CTRL) &&
                       bus_wdata[C_GO] && !eng_busy;
    assign eng_op    = bus_wdata[C_INIT] ? OP_BRK :
                       (bus_wdata[C_DIR] ? OP_RX : OP_TX);

    hdq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(line_in), .dout(line_s)
    );

    hdq_prescaler #(.DIV(TICK_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .clear(eng_start), .tick(tick)
    );

    hdq_line_engine #(
        .ONE_LOW(ONE_LOW), .ZERO_LOW(ZERO_LOW), .CELL(CELL),
        .BRK_LOW(BRK_LOW), .BRK_REC(BRK_REC),
        .RX_WAIT(RX_WAIT), .RX_SAMPLE(RX_SAMPLE)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .abort(soft_rst), .tick(tick),
        .start(eng_start), .op(eng_op), .tx_byte(q.txd), .line_s(line_s),
        .drive_low(line_pull_low), .busy(eng_busy),
        .done_flags(eng_done), .rx_byte(eng_rx)
    );

    always_comb begin
        d = q;
        if (!srst_done) begin
            d.srst = q.srst - SW'(1);
        end else begin
            if (bus_rd && (bus_addr == A_ISR) && q.ctrl[C_IE]) d.flags = '0;
            d.flags = d.flags | eng_done;
            if ((|eng_done) && q.ctrl[C_IE]) begin
                d.ctrl[C_GO]   = 1'b0;
                d.ctrl[C_INIT] = 1'b0;
            end
            if (eng_done[F_RX]) d.rxd = eng_rx;
            if (bus_wr) begin
                case (bus_addr)
                    A_TXD:   d.txd = bus_wdata;
                    A_CTRL:  if (!eng_busy) d.ctrl = bus_wdata & CTRL_MASK;
                    A_SYSC:  d.aidle = bus_wdata[0];
                    default: ;
                endcase
            end
            if (soft_rst) begin
                d      = '0;
                d.srst = SW'(SRST_CYCLES);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.srst <= SW'(SRST_CYCLES);
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (bus_addr)
            A_REV:   rdata = {REV_MAJOR, REV_MINOR};
            A_TXD:   rdata = q.txd;
            A_RXD:   rdata = q.rxd;
            A_CTRL:  rdata = q.ctrl;
            A_ISR:   rdata = {5'b0, q.flags};
            A_SYSC:  rdata = {7'b0, q.aidle};
            A_SYSS:  rdata = {7'b0, srst_done};
            default: rdata = 8'h00;
        endcase
    end

    assign bus_rdata = bus_rd ? rdata : 8'h00;
    assign irq       = q.ctrl[C_IE] && (|q.flags);
    assign chk_ctrl  = q.ctrl;
    assign chk_flags = q.flags;
endmodule

// File: rtl/hdq_master_chk.sv
module hdq_master_chk
    import hdq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_wdata,
    input logic [7:0] ctrl_q,
    input logic [2:0] flags_q,
    input logic [2:0] eng_done,
    input logic       srst_done,
    input logic       line_pull_low
);
    // R12: the wire is only pulled while an operation holds GO
    assert_pull_needs_go_R12: assert property (@(posedge clk) disable iff (!rst_n)
        line_pull_low |-> ctrl_q[C_GO]);

    // R3, R4, R5, R6: a new flag only appears after the engine reports an end
    assert_flag_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flags_q & ~$past(flags_q))) |-> (|$past(eng_done)));

    // R3: GO self-clears when an operation ends with IE set
    assert_go_selfclear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((|eng_done) && ctrl_q[C_IE] && !(bus_wr && bus_addr == A_CTRL))
        |=> !ctrl_q[C_GO] && !ctrl_q[C_INIT]);

    // R8: status read with IE set clears the flags
    assert_clear_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_ISR && ctrl_q[C_IE] && eng_done == 3'b0)
        |=> flags_q == 3'b0);

    // R9: without IE a status read keeps every flag
    assert_keep_without_ie_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == A_ISR && !ctrl_q[C_IE])
        |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R10: soft reset returns control and flags to zero
    assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_SYSC && bus_wdata[1] && srst_done)
        |=> (ctrl_q == 8'h00) && (flags_q == 3'b0));

    // R3, R5, R6: only one kind of ending per operation
    assert_single_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eng_done));
endmodule

bind hdq_master hdq_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .ctrl_q(chk_ctrl),
    .flags_q(chk_flags), .eng_done(eng_done), .srst_done(srst_done),
    .line_pull_low(line_pull_low)
);

// File: tb/hdq_master_tb.sv
`timescale 1ns/1ps
module hdq_master_tb;
    localparam int DIV = 4, T1 = 4, T0 = 12, TC = 24, TBL = 30, TBR = 8;
    localparam int TRW = 40, TRS = 8, SRST = 6;
    localparam logic [3:0] MAJ = 4'd1, MIN = 4'd3;
    localparam int THR = ((T1 + T0) / 2) * DIV;

    logic clk = 0, rst_n = 0;
    logic [4:0] bus_addr = '0;
    logic bus_wr = 0, bus_rd = 0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic irq, line_pull_low;
    logic slave_low = 0;
    logic line;
    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;

    assign line = !(line_pull_low || slave_low);

    always #2 clk = ~clk;

    hdq_master #(
        .TICK_DIV(DIV), .ONE_LOW(T1), .ZERO_LOW(T0), .CELL(TC),
        .BRK_LOW(TBL), .BRK_REC(TBR), .RX_WAIT(TRW), .RX_SAMPLE(TRS),
        .SRST_CYCLES(SRST), .SYNC_STAGES(2), .REV_MAJOR(MAJ), .REV_MINOR(MIN)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .line_pull_low(line_pull_low), .line_in(line)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [4:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic bread(input logic [4:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    function automatic int ctl(input bit ie, input bit go, input bit init, input bit dir);
        return (ie << 6) | (go << 4) | (init << 2) | (dir << 1);
    endfunction

    task automatic wait_irq(input int maxc, output bit ok);
        ok = 0;
        for (int i = 0; i < maxc; i++) begin
            if (irq) begin ok = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic capture_tx(output logic [7:0] b);
        b = '0;
        for (int i = 0; i < 8; i++) begin
            int w = 0, g = 0;
            while (!line_pull_low && g < 400) begin @(negedge clk); g++; end
            while (line_pull_low && w < 400) begin @(negedge clk); w++; end
            b[i] = (w < THR);
        end
    endtask

    task automatic slave_send(input logic [7:0] b, output int pulls);
        pulls = 0;
        repeat (40) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            slave_low = 1;
            for (int k = 0; k < (b[i] ? T1 * DIV : (T0 + 2) * DIV); k++) begin
                @(negedge clk); if (line_pull_low) pulls++;
            end
            slave_low = 0;
            for (int k = 0; k < 60; k++) begin
                @(negedge clk); if (line_pull_low) pulls++;
            end
        end
    endtask

    task automatic do_tx(input logic [7:0] v);
        logic [7:0] got, r;
        bit ok;
        bwrite(5'h04, v);
        bwrite(5'h0C, 8'(ctl(1, 1, 0, 0)));
        capture_tx(got);
        chk("R2 tx byte on line", got, v);
        wait_irq(400, ok);
        chk("R8 irq after tx", ok, 1);
        bread(5'h0C, r);
        chk("R3 GO cleared after tx", r, ctl(1, 0, 0, 0));
        bread(5'h10, r);
        chk("R3 tx flag", r, 8'h04);
        chk("R8 irq low after read", irq, 0);
        bread(5'h10, r);
        chk("R8 flags cleared by read", r, 8'h00);
    endtask

    task automatic do_rx(input logic [7:0] v);
        logic [7:0] r;
        bit ok;
        int pulls;
        bwrite(5'h0C, 8'(ctl(1, 1, 0, 1)));
        slave_send(v, pulls);
        chk("R12 no pull during rx", pulls, 0);
        wait_irq(200, ok);
        chk("R5 irq after rx", ok, 1);
        bread(5'h10, r);
        chk("R5 rx flag", r, 8'h02);
        bread(5'h08, r);
        chk("R5 rx byte", r, v);
        bread(5'h0C, r);
        chk("R5 GO cleared after rx", r, ctl(1, 0, 0, 1));
    endtask

    initial begin
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] r, v1, v2, got;
        bit ok;
        int w, pulls;
        void'($urandom(32'h1d2c3b4a));
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        bread(5'h18, r);
        chk("R1 reset-done low after reset", r, 0);
        repeat (10) @(negedge clk);
        bread(5'h18, r);
        chk("R1 reset-done high", r, 1);
        bread(5'h00, r);
        chk("R1 revision", r, {MAJ, MIN});
        bread(5'h0C, r); chk("R1 ctrl default", r, 0);
        bread(5'h10, r); chk("R1 status default", r, 0);
        bread(5'h04, r); chk("R1 tx default", r, 0);
        bread(5'h08, r); chk("R1 rx default", r, 0);
        bread(5'h1C, r); chk("R1 unmapped reads zero", r, 0);
        chk("R12 idle line released", line_pull_low, 0);

        bwrite(5'h0C, 8'(ctl(1, 0, 0, 0)));

        // R2 R3: corner bytes and random bytes
        do_tx(8'h00);
        do_tx(8'hFF);
        for (int i = 0; i < 3; i++) do_tx(8'($urandom));

        // R4: break pulse
        bwrite(5'h0C, 8'(ctl(1, 1, 1, 0)));
        w = 0;
        while (line_pull_low && w < 1000) begin @(negedge clk); w++; end
        chk("R4 break low width in range", (w >= TBL * DIV - 3) && (w <= TBL * DIV + 1), 1);
        wait_irq(200, ok);
        chk("R4 irq after break", ok, 1);
        bread(5'h10, r); chk("R4 timeout flag", r, 8'h01);
        bread(5'h0C, r); chk("R4 INIT and GO clear", r, ctl(1, 0, 0, 0));

        // R5: receive
        do_rx(8'h00);
        do_rx(8'hFF);
        for (int i = 0; i < 2; i++) do_rx(8'($urandom));

        // R6: receive timeout
        bwrite(5'h0C, 8'(ctl(1, 1, 0, 1)));
        pulls = 0; ok = 0;
        for (int i = 0; i < 400; i++) begin
            if (line_pull_low) pulls++;
            if (irq) begin ok = 1; break; end
            @(negedge clk);
        end
        chk("R6 irq on rx timeout", ok, 1);
        chk("R12 no pull in rx timeout", pulls, 0);
        bread(5'h10, r); chk("R6 timeout flag only", r, 8'h01);
        bread(5'h0C, r); chk("R6 GO cleared", r, ctl(1, 0, 0, 1));

        // R7: receive right after transmit
        v1 = 8'($urandom); v2 = 8'($urandom);
        bwrite(5'h04, v1);
        bwrite(5'h0C, 8'(ctl(1, 1, 0, 0)));
        capture_tx(got);
        chk("R2 command byte", got, v1);
        while (!irq) @(negedge clk);
        bus_addr = 5'h0C; bus_wdata = 8'(ctl(1, 1, 0, 1)); bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
        slave_send(v2, pulls);
        repeat (20) @(negedge clk);
        bread(5'h10, r); chk("R7 both flags", r, 8'h06);
        bread(5'h08, r); chk("R7 rx byte after tx", r, v2);

        // R11: control write during an operation is ignored
        bwrite(5'h04, 8'hA5);
        bwrite(5'h0C, 8'(ctl(1, 1, 0, 0)));
        repeat (20) @(negedge clk);
        bwrite(5'h0C, 8'h00);
        wait_irq(1500, ok);
        chk("R11 op completes with IE kept", ok, 1);
        bread(5'h0C, r); chk("R11 ctrl unchanged", r, ctl(1, 0, 0, 0));
        bread(5'h10, r);

        // R9: no clear without IE
        bwrite(5'h0C, 8'h00);
        bwrite(5'h04, 8'($urandom));
        bwrite(5'h0C, 8'(ctl(0, 1, 0, 0)));
        w = 0;
        for (int i = 0; i < 1000; i++) begin @(negedge clk); if (irq) w++; end
        chk("R9 irq stays low", w, 0);
        bread(5'h10, r); chk("R9 flag set", r, 8'h04);
        bread(5'h10, r); chk("R9 flag kept after read", r, 8'h04);
        bread(5'h0C, r); chk("R9 GO stays set", r, ctl(0, 1, 0, 0));
        bwrite(5'h0C, 8'(ctl(1, 0, 0, 0)));
        chk("R8 irq follows IE", irq, 1);
        bread(5'h10, r); chk("R8 read returns flag", r, 8'h04);
        bread(5'h10, r); chk("R8 cleared", r, 8'h00);

        // R10: soft reset in the middle of a transfer
        bwrite(5'h14, 8'h01);
        bread(5'h14, r); chk("R10 auto-idle readback", r, 8'h01);
        bwrite(5'h04, 8'h00);
        bwrite(5'h0C, 8'(ctl(1, 1, 0, 0)));
        repeat (5) @(negedge clk);
        bwrite(5'h14, 8'h02);
        chk("R10 line released", line_pull_low, 0);
        bread(5'h18, r); chk("R10 reset-done low", r, 0);
        bwrite(5'h04, 8'h77);
        repeat (10) @(negedge clk);
        bread(5'h18, r); chk("R10 reset-done high", r, 1);
        bread(5'h04, r); chk("R10 tx default and write ignored", r, 0);
        bread(5'h0C, r); chk("R10 ctrl default", r, 0);
        bread(5'h14, r); chk("R10 config default", r, 0);
        w = 0;
        for (int i = 0; i < 300; i++) begin @(negedge clk); if (line_pull_low || irq) w++; end
        chk("R10 operation aborted", w, 0);
        bread(5'h10, r); chk("R10 no flag after abort", r, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule